// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block sits on the device side of an asynchronous DRAM strobe interface and samples the row strobe, column strobe, write enable, output enable and the multiplexed address bus in a fast system clock domain. It works out which kind of memory cycle the controller ran only from the order in which the strobes move. The kinds it knows are read, early write, late write, read-modify-write, page-mode access, row-only refresh, CAS-before-RAS refresh, hidden refresh and self-refresh. It latches the row and column addresses on the edges that carry them. For refresh cycles it also supplies the row from an internal refresh counter.

It also drives a data-output enable with extended-data-out hold behaviour. Read data stays enabled after the column strobe rises. It is dropped only when both strobes are high, when output enable goes high, or when a write begins. This enable is the signal a memory model needs to drive its data pins, and it is the signal a protocol checker needs to watch bus ownership.

A one-cycle report gives the class of each finished cycle. Two pulse outputs flag a page-mode column period that is too short and a row strobe held low too long. All strobe and enable pins are active low. The block has no streamed data path, so every port is a plain level or pulse with no handshake.

Top module: `dram_cycle_sorter`

## Requirements
- R1: After reset, dq_oe, cls_valid, viol_tpc and viol_ras are 0, and the refresh counter holds row 0.
- R2: A row strobe fall with the column strobe high latches addr as row_addr. Each column strobe fall while the row strobe is low latches addr as col_addr. A cycle with exactly one column fall, write enable high throughout, is reported as read (code 0).
- R3: Write enable low when the column strobe falls makes an early write (code 1), and dq_oe stays 0 for that column.
- R4: Write enable falling after the column strobe fell makes a write of the late kind. It is late write (code 2) if output enable stayed high until then, and read-modify-write (code 3) if output enable was low. In read-modify-write, dq_oe is 1 before the write enable fall and 0 after it. So with output enable held low, code 2 cannot occur.
- R5: Two or more column strobe falls in one row-low period are reported as page mode (code 4).
- R6: A row-low period with no column strobe fall is reported as row-only refresh (code 5), with row_addr taken from addr at the row strobe fall.
- R7: The column strobe already low when the row strobe falls makes a CAS-before-RAS refresh (code 6). row_addr takes the refresh counter value, and the counter then advances by one, modulo 2^ROW_W. The counter advances on every such entry, including hidden refresh and self-refresh.
- R8: If the column strobe is held low from a read through the row strobe going high and then low again, the result is a hidden refresh (code 7). dq_oe stays 1 during that refresh.
- R9: A CAS-before-RAS cycle whose row strobe stays low for at least SELF_CYC clock cycles is reported as self-refresh (code 8).
- R10: dq_oe stays 1 after the column strobe rises while the row strobe is low. It goes to 0 once both strobes are high or output enable is high, and it returns when output enable goes low again.
- R11: viol_tpc pulses for one cycle when a column strobe fall follows the previous one in the same row-low period by fewer than TPC_MIN cycles. A period of TPC_MIN or more gives no pulse.
- R12: viol_ras pulses once when the row strobe of a non-refresh cycle has been low for RAS_MAX cycles. Refresh cycles never raise it.
- R13: cls_valid is a one-cycle pulse per cycle. It is visible from the second rising clock edge after the row strobe is sampled high, and cls_code is valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_W (11) | Multiplexed row/column address |
| row_addr | output | ROW_W (11) | Row of the current or most recent cycle |
| col_addr | output | ROW_W (11) | Most recent column address |
| dq_oe | output | 1 | Data-output enable with EDO hold |
| cls_valid | output | 1 | One-cycle report of a finished cycle |
| cls_code | output | 4 | Cycle class, valid with cls_valid |
| viol_tpc | output | 1 | Page column period too short |
| viol_ras | output | 1 | Row strobe low beyond RAS_MAX |

## Verification
The per-cycle flags that decide the class appear at the ports only once, in the report two clock edges after the row strobe rises. So a wrong early, late or read-seen flag is caught at the end of the same cycle, through cls_code. A corrupted refresh counter stays hidden until the next CAS-before-RAS entry, where it shows up directly on row_addr. For that reason the tests run refresh entries back to back and inside a hidden refresh. A wrong data-valid flag shows on dq_oe one cycle after the strobe edge that should have set or cleared it. The tests therefore probe dq_oe after column rise, after output enable toggles, during the hidden refresh, and after both strobes are high.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [3:0] {
    CYC_READ    = 4'd0,
    CYC_EARLY   = 4'd1,
    CYC_LATE    = 4'd2,
    CYC_RMW     = 4'd3,
    CYC_PAGE    = 4'd4,
    CYC_RONLY   = 4'd5,
    CYC_CBR     = 4'd6,
    CYC_HIDDEN  = 4'd7,
    CYC_SELF    = 4'd8
  } cyc_kind_e;

  localparam int NSTB   = 4;
  localparam int NEDGE  = 3;
  localparam int IX_RAS = 0;
  localparam int IX_CAS = 1;
  localparam int IX_WE  = 2;
  localparam int IX_OE  = 3;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dcs_sampler.sv
module dcs_sampler
  import dcs_pkg::*;
#(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSTB-1:0]  stb_raw,
  input  logic [ROW_W-1:0] addr_raw,
  output logic [NSTB-1:0]  stb_q,
  output logic [ROW_W-1:0] addr_q,
  output logic [NEDGE-1:0] fall,
  output logic             ras_rise
);
  logic [NEDGE-1:0] stb_p;

  for (genvar gi = 0; gi < NSTB; gi++) begin : g_smp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_q[gi] <= 1'b1;
      else        stb_q[gi] <= stb_raw[gi];
    end
  end

  for (genvar ge = 0; ge < NEDGE; ge++) begin : g_edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_p[ge] <= 1'b1;
      else        stb_p[ge] <= stb_q[ge];
    end
    assign fall[ge] = stb_p[ge] & ~stb_q[ge];
  end

  assign ras_rise = ~stb_p[IX_RAS] & stb_q[IX_RAS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_raw;
  end
endmodule

// File: rtl/dcs_refresh_ctr.sv
module dcs_refresh_ctr #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   row <= '0;
    else if (adv) row <= row + 1'b1;
  end
endmodule

// File: rtl/dcs_timing_mon.sv
module dcs_timing_mon
  import dcs_pkg::*;
#(
  parameter int RAS_MAX  = 1000,
  parameter int SELF_CYC = 10000,
  parameter int TPC_MIN  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_ras,
  input  logic ras_fall,
  input  logic cas_fall,
  input  logic refresh_cyc,
  output logic ras_long,
  output logic viol_ras,
  output logic viol_tpc
);
  localparam int CMAX = imax(RAS_MAX, SELF_CYC) + 1;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int GW   = $clog2(TPC_MIN + 1);
  localparam logic [CW-1:0] C_TOP  = CW'(CMAX);
  localparam logic [CW-1:0] C_RMAX = CW'(RAS_MAX);
  localparam logic [CW-1:0] C_SELF = CW'(SELF_CYC);
  localparam logic [GW-1:0] G_TOP  = GW'(TPC_MIN);

  logic [CW-1:0] low_cnt;
  logic [GW-1:0] gap;
  logic          arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_cnt <= '0;
    else if (s_ras)            low_cnt <= '0;
    else if (low_cnt != C_TOP) low_cnt <= low_cnt + 1'b1;
  end

  assign ras_long = (low_cnt >= C_SELF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap      <= '0;
      arm      <= 1'b0;
      viol_tpc <= 1'b0;
      viol_ras <= 1'b0;
    end else begin
      if (cas_fall)          gap <= GW'(1);
      else if (gap != G_TOP) gap <= gap + 1'b1;

      if (ras_fall)                 arm <= 1'b0;
      else if (cas_fall && !s_ras)  arm <= 1'b1;

      viol_tpc <= cas_fall && !s_ras && arm && !refresh_cyc && (gap < G_TOP);
      viol_ras <= !s_ras && !refresh_cyc && (low_cnt == C_RMAX);
    end
  end

  // R11: a short-period flag always follows a sampled column fall
  p_tpc_follows_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    viol_tpc |-> $past(cas_fall));

  // R12: a long-low flag is never raised while the row strobe is sampled high
  p_ras_flag_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    viol_ras |-> $past(!s_ras));
endmodule

// File: rtl/dcs_classifier.sv
module dcs_classifier
  import dcs_pkg::*;
#(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_ras,
  input  logic             s_cas,
  input  logic             s_we,
  input  logic             s_oe,
  input  logic [ROW_W-1:0] s_addr,
  input  logic             ras_fall,
  input  logic             ras_rise,
  input  logic             cas_fall,
  input  logic             we_fall,
  input  logic [ROW_W-1:0] ref_row,
  input  logic             ras_long,
  output logic             ref_adv,
  output logic             refresh_cyc,
  output logic [ROW_W-1:0] row_addr,
  output logic [ROW_W-1:0] col_addr,
  output logic             dq_oe,
  output logic             cls_valid,
  output logic [3:0]       cls_code
);
  logic       hid_cyc, hid_arm;
  logic [1:0] cas_cnt;
  logic       early, late, rd_seen, data_vld;
  cyc_kind_e  kind;

  assign ref_adv = ras_fall && !s_cas;

  always_comb begin
    if (refresh_cyc) begin
      if (ras_long)     kind = CYC_SELF;
      else if (hid_cyc) kind = CYC_HIDDEN;
      else              kind = CYC_CBR;
    end else if (cas_cnt == 2'd0) kind = CYC_RONLY;
    else if (cas_cnt >= 2'd2)     kind = CYC_PAGE;
    else if (late)                kind = rd_seen ? CYC_RMW : CYC_LATE;
    else if (early)               kind = CYC_EARLY;
    else                          kind = CYC_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refresh_cyc <= 1'b0;
      hid_cyc     <= 1'b0;
      cas_cnt     <= '0;
      early       <= 1'b0;
      late        <= 1'b0;
      rd_seen     <= 1'b0;
      row_addr    <= '0;
      col_addr    <= '0;
    end else if (ras_fall) begin
      refresh_cyc <= !s_cas;
      hid_cyc     <= !s_cas && hid_arm;
      cas_cnt     <= '0;
      early       <= 1'b0;
      late        <= 1'b0;
      rd_seen     <= 1'b0;
      row_addr    <= s_cas ? s_addr : ref_row;
    end else if (!s_ras && !refresh_cyc) begin
      if (cas_fall) begin
        col_addr <= s_addr;
        if (cas_cnt != 2'd3) cas_cnt <= cas_cnt + 1'b1;
        if (!s_we) early <= 1'b1;
      end
      if (we_fall && !s_cas && cas_cnt != 2'd0) late <= 1'b1;
      if (!s_cas && !s_oe && s_we && !late && cas_cnt != 2'd0) rd_seen <= 1'b1;
    end
  end

  // hidden-refresh arming: column strobe still low with data live at row rise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hid_arm <= 1'b0;
    else if (ras_rise) hid_arm <= !s_cas && data_vld;
    else if (s_cas)    hid_arm <= 1'b0;
  end

  // EDO data-valid: survives column rise, dropped by idle or by a write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               data_vld <= 1'b0;
    else if (s_ras && s_cas)                  data_vld <= 1'b0;
    else if (cas_fall && !s_ras && !refresh_cyc) data_vld <= s_we;
    else if (we_fall && !s_ras && !refresh_cyc)  data_vld <= 1'b0;
  end

  assign dq_oe = data_vld && !s_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_valid <= 1'b0;
      cls_code  <= CYC_READ;
    end else begin
      cls_valid <= ras_rise;
      if (ras_rise) cls_code <= kind;
    end
  end

  // R10: both strobes high leaves the data pins undriven on the next cycle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ras && s_cas) |=> !dq_oe);

  // R3: an early-write column never enables the outputs
  p_early_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_fall && !s_ras && !s_we && !refresh_cyc) |=> !dq_oe);

  // R13: the class report lasts one cycle
  p_report_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cls_valid |=> !cls_valid);

  // R7: a refresh entry takes its row from the counter
  p_refresh_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_adv |=> (row_addr == $past(ref_row)));
endmodule

// File: rtl/dram_cycle_sorter.sv
module dram_cycle_sorter
  import dcs_pkg::*;
#(
  parameter int ROW_W    = 11,
  parameter int RAS_MAX  = 1000,
  parameter int SELF_CYC = 10000,
  parameter int TPC_MIN  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [ROW_W-1:0] addr,
  output logic [ROW_W-1:0] row_addr,
  output logic [ROW_W-1:0] col_addr,
  output logic             dq_oe,
  output logic             cls_valid,
  output logic [3:0]       cls_code,
  output logic             viol_tpc,
  output logic             viol_ras
);
  logic [NSTB-1:0]  stb_raw, stb_q;
  logic [NEDGE-1:0] fall;
  logic [ROW_W-1:0] addr_q, ref_row;
  logic             ras_rise, ras_long, ref_adv, refresh_cyc;

  always_comb begin
    stb_raw         = '1;
    stb_raw[IX_RAS] = ras_n;
    stb_raw[IX_CAS] = cas_n;
    stb_raw[IX_WE]  = we_n;
    stb_raw[IX_OE]  = oe_n;
  end

  dcs_sampler #(.ROW_W(ROW_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .stb_raw(stb_raw), .addr_raw(addr),
    .stb_q(stb_q), .addr_q(addr_q), .fall(fall), .ras_rise(ras_rise)
  );

  dcs_refresh_ctr #(.ROW_W(ROW_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .adv(ref_adv), .row(ref_row)
  );

  dcs_timing_mon #(.RAS_MAX(RAS_MAX), .SELF_CYC(SELF_CYC), .TPC_MIN(TPC_MIN)) u_tmon (
    .clk(clk), .rst_n(rst_n), .s_ras(stb_q[IX_RAS]), .ras_fall(fall[IX_RAS]),
    .cas_fall(fall[IX_CAS]), .refresh_cyc(refresh_cyc), .ras_long(ras_long),
    .viol_ras(viol_ras), .viol_tpc(viol_tpc)
  );

  dcs_classifier #(.ROW_W(ROW_W)) u_cls (
    .clk(clk), .rst_n(rst_n),
    .s_ras(stb_q[IX_RAS]), .s_cas(stb_q[IX_CAS]), .s_we(stb_q[IX_WE]), .s_oe(stb_q[IX_OE]),
    .s_addr(addr_q), .ras_fall(fall[IX_RAS]), .ras_rise(ras_rise),
    .cas_fall(fall[IX_CAS]), .we_fall(fall[IX_WE]), .ref_row(ref_row),
    .ras_long(ras_long), .ref_adv(ref_adv), .refresh_cyc(refresh_cyc),
    .row_addr(row_addr), .col_addr(col_addr), .dq_oe(dq_oe),
    .cls_valid(cls_valid), .cls_code(cls_code)
  );
endmodule

// File: tb/test_dram_cycle_sorter.sv
module test_dram_cycle_sorter;
  localparam int ROW_W    = 11;
  localparam int RAS_MAX  = 1000;
  localparam int SELF_CYC = 10000;
  localparam int TPC_MIN  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [ROW_W-1:0] addr = '0;
  logic [ROW_W-1:0] row_addr, col_addr;
  logic dq_oe, cls_valid, viol_tpc, viol_ras;
  logic [3:0] cls_code;

  int n_chk = 0, n_bad = 0;
  int n_cls = 0, n_tpc = 0, n_rasv = 0;
  logic [3:0] last_cls = 4'hF;
  int exp_ref = 0;

  always #5 clk = ~clk;

  dram_cycle_sorter #(.ROW_W(ROW_W), .RAS_MAX(RAS_MAX), .SELF_CYC(SELF_CYC),
                      .TPC_MIN(TPC_MIN)) i_dram_cycle_sorter (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .row_addr(row_addr), .col_addr(col_addr),
    .dq_oe(dq_oe), .cls_valid(cls_valid), .cls_code(cls_code),
    .viol_tpc(viol_tpc), .viol_ras(viol_ras)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (cls_valid) begin n_cls++; last_cls = cls_code; end
      if (viol_tpc) n_tpc++;
      if (viol_ras) n_rasv++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 dq_oe after reset", dq_oe, 0);
    check("R1 cls_valid after reset", cls_valid, 0);
    check("R1 viol pins after reset", {viol_tpc, viol_ras}, 0);
  endtask

  task automatic t_cbr();
    int nc;
    nc = n_cls;
    cas_n = 0; step(3);
    ras_n = 0; step(3);
    check("R7 CBR row from counter", row_addr, exp_ref);
    exp_ref++;
    ras_n = 1; step(3);
    cas_n = 1; step(3);
    check("R7 CBR class", last_cls, 6);
    check("R13 one report per cycle", n_cls - nc, 1);
  endtask

  task automatic t_read(input int row, input int col);
    int nc;
    nc = n_cls;
    addr = row[ROW_W-1:0]; ras_n = 0; step(3);
    addr = col[ROW_W-1:0]; cas_n = 0; step(3);
    check("R2 row latched", row_addr, row);
    check("R2 column latched", col_addr, col);
    check("R2 read data enabled", dq_oe, 1);
    cas_n = 1; step(3);
    check("R10 hold after column rise", dq_oe, 1);
    oe_n = 1; step(2);
    check("R10 off with output enable high", dq_oe, 0);
    oe_n = 0; step(2);
    check("R10 back with output enable low", dq_oe, 1);
    ras_n = 1; step(1);
    check("R13 no report before second edge", cls_valid, 0);
    step(1);
    check("R13 report at second edge", cls_valid, 1);
    step(1);
    check("R13 report one cycle", cls_valid, 0);
    check("R10 off with both strobes high", dq_oe, 0);
    check("R2 read class", last_cls, 0);
    check("R13 one report for read", n_cls - nc, 1);
  endtask

  task automatic t_early();
    addr = 11'h155; ras_n = 0; step(2);
    we_n = 0; step(2);
    addr = 11'h0AA; cas_n = 0; step(3);
    check("R3 early write keeps output off", dq_oe, 0);
    cas_n = 1; ras_n = 1; we_n = 1; step(3);
    check("R3 early write class", last_cls, 1);
  endtask

  task automatic t_late();
    oe_n = 1;
    addr = 11'h321; ras_n = 0; step(3);
    addr = 11'h012; cas_n = 0; step(3);
    we_n = 0; step(3);
    we_n = 1; cas_n = 1; ras_n = 1; step(3);
    check("R4 late write class", last_cls, 2);
    oe_n = 0; step(2);
  endtask

  task automatic t_rmw();
    addr = 11'h400; ras_n = 0; step(3);
    addr = 11'h033; cas_n = 0; step(3);
    check("R4 read half drives data", dq_oe, 1);
    we_n = 0; step(3);
    check("R4 write half releases data", dq_oe, 0);
    we_n = 1; cas_n = 1; ras_n = 1; step(3);
    check("R4 read-modify-write class", last_cls, 3);
  endtask

  task automatic t_page(input int lo, input int hi, input int exp_viol);
    int nt;
    nt = n_tpc;
    addr = 11'h077; ras_n = 0; step(3);
    for (int k = 0; k < 3; k++) begin
      addr = 11'(16 + k); cas_n = 0; step(lo);
      cas_n = 1; step(hi);
    end
    step(3);
    check("R5 page last column", col_addr, 18);
    check("R11 short column period flags", n_tpc - nt, exp_viol);
    ras_n = 1; step(3);
    check("R5 page class", last_cls, 4);
  endtask

  task automatic t_ronly();
    addr = 11'h2C5; ras_n = 0; step(4);
    check("R6 row-only row latched", row_addr, 11'h2C5);
    check("R6 row-only output off", dq_oe, 0);
    ras_n = 1; step(3);
    check("R6 row-only class", last_cls, 5);
  endtask

  task automatic t_hidden();
    addr = 11'h111; ras_n = 0; step(3);
    addr = 11'h222; cas_n = 0; step(3);
    check("R8 read before hidden", dq_oe, 1);
    ras_n = 1; step(3);
    check("R8 first part reported as read", last_cls, 0);
    check("R10 column low holds data", dq_oe, 1);
    ras_n = 0; step(3);
    check("R8 hidden row from counter", row_addr, exp_ref);
    exp_ref++;
    check("R8 data stays during refresh", dq_oe, 1);
    ras_n = 1; step(3);
    check("R8 hidden class", last_cls, 7);
    cas_n = 1; step(3);
    check("R10 dropped when idle", dq_oe, 0);
  endtask

  task automatic t_self();
    int nr;
    nr = n_rasv;
    cas_n = 0; step(3);
    ras_n = 0; step(SELF_CYC + 20);
    exp_ref++;
    ras_n = 1; step(3);
    cas_n = 1; step(3);
    check("R9 self-refresh class", last_cls, 8);
    check("R12 refresh exempt from long-low flag", n_rasv - nr, 0);
  endtask

  task automatic t_rasmax();
    int nr;
    nr = n_rasv;
    addr = 11'h00F; ras_n = 0; step(3);
    cas_n = 0; step(RAS_MAX + 10);
    check("R12 long row strobe flagged once", n_rasv - nr, 1);
    cas_n = 1; ras_n = 1; step(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1; step(2);
    t_cbr();
    t_cbr();
    t_read(11'h3A5, 11'h05C);
    t_read(11'h001, 11'h7FF);
    t_early();
    t_late();
    t_rmw();
    t_page(2, 2, 0);
    t_page(1, 1, 2);
    t_ronly();
    t_hidden();
    t_cbr();
    t_self();
    t_cbr();
    t_rasmax();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule